// File: doc/BRIEF.md
# Per-Sink Trace ID Filter

This block sits between one shared trace stream and several trace buffer sinks (two by default). Every incoming beat carries a trace ID and a data word. Each sink owns an allow mask with one bit per possible trace ID. A beat is offered to exactly those sinks whose mask has the bit for its ID set. A beat that no sink wants is taken and thrown away. The mask of each sink is split into 32-bit words. Software reads and writes these words through a small register port. It can also set or clear one bit, addressed by sink and ID, in a single atomic operation. This lets a trace source be switched on or off without a read-modify-write sequence.

The beat path is a two-state machine. In `ST_EMPTY` the block is ready for input. An accepted beat takes a snapshot of the per-sink selection from the masks at that moment. If any sink is selected, the transition `EMPTY->DELIVER` is taken. If no sink is selected, the transition `EMPTY->EMPTY (drop)` is taken. In `ST_DELIVER` the captured beat is offered to every sink still pending, and each sink takes it on its own handshake. The transition `DELIVER->DELIVER` holds while any sink is still pending. The transition `DELIVER->EMPTY` is taken on the cycle that the last pending sink takes the beat.

Top module: `trace_id_filter`

## Requirements
- R1: After reset every mask bit is zero, every register reads 0, `in_ready` is 1 and `out_valid` is all zero.
- R2: Register index `reg_addr` = sink × 4 + ID[6:5], and bit ID[4:0] of that word belongs to ID. A write operation (`reg_op`=1) replaces the whole addressed word with `reg_wdata`. `reg_rdata` always shows the word at `reg_addr` and leaves the other words alone.
- R3: A set operation (`reg_op`=2) sets only the bit for `reg_id` in the mask of `reg_sink`. Every other bit keeps its value.
- R4: A clear operation (`reg_op`=3) clears only the bit for `reg_id` in the mask of `reg_sink`. Every other bit keeps its value. `reg_op`=0 does nothing.
- R5: An accepted beat whose ID bit is set in sink s's mask raises `out_valid[s]` in the next cycle, with `out_id`/`out_data` equal to the beat. A sink whose bit is clear never sees `out_valid` for that beat.
- R6: A beat selected by several sinks is offered to all of them at once. Each sink drops its `out_valid` in the cycle after its own `out_ready` handshake. `out_id`/`out_data` stay stable while any sink is still pending.
- R7: `in_ready` is low exactly while some selected sink has not yet taken the current beat. The next beat is accepted only after all selected sinks have taken it.
- R8: A beat selected by no sink is accepted and discarded. No `out_valid` rises and `in_ready` stays high.
- R9: A mask change made while a beat is pending does not alter which sinks receive that beat. It applies from the next accepted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_id | input | 7 | Trace ID of input beat |
| in_data | input | 32 | Trace payload of input beat |
| out_valid | output | 2 | Per-sink beat valid |
| out_ready | input | 2 | Per-sink ready |
| out_id | output | 7 | Trace ID of the pending beat |
| out_data | output | 32 | Payload of the pending beat |
| reg_op | input | 2 | 0 none, 1 write word, 2 set bit, 3 clear bit |
| reg_addr | input | 3 | Word index for write and read |
| reg_sink | input | 1 | Sink for set/clear |
| reg_id | input | 7 | Trace ID for set/clear |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Word at reg_addr |

## Verification
The bench builds the block with its default parameters: two sinks, 7-bit IDs and 32-bit words. This gives eight mask words, so both sinks, all four words of a sink and the top and bottom bits of a word can be reached by a directed test. With two sinks the bench can drive mixed handshakes, where one sink takes a beat while the other stalls. It also covers single-sink routing in both directions, the unselected drop and a mask edit made while a beat is pending.

// File: rtl/trf_pkg.sv
package trf_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLR   = 2'd3
    } reg_op_e;

    typedef enum logic {
        ST_EMPTY   = 1'b0,
        ST_DELIVER = 1'b1
    } dlv_state_e;
endpackage

// File: rtl/trf_mask_bank.sv
module trf_mask_bank #(
    parameter int NUM_SINKS = 2,
    parameter int ID_W      = 7,
    parameter int REG_W     = 32,
    localparam int NUM_IDS  = 1 << ID_W,
    localparam int WORDS    = NUM_IDS / REG_W,
    localparam int NUM_REGS = NUM_SINKS * WORDS,
    localparam int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int SINK_W   = (NUM_SINKS > 1) ? $clog2(NUM_SINKS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  trf_pkg::reg_op_e             reg_op,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [SINK_W-1:0]            reg_sink,
    input  logic [ID_W-1:0]              reg_id,
    input  logic [REG_W-1:0]             reg_wdata,
    output logic [REG_W-1:0]             reg_rdata,
    input  logic [ID_W-1:0]              look_id,
    output logic [NUM_SINKS-1:0]         look_sel,
    output logic [NUM_SINKS*NUM_IDS-1:0] mask_flat
);
    import trf_pkg::*;

    for (genvar s = 0; s < NUM_SINKS; s++) begin : g_sink
        logic [NUM_IDS-1:0] mask_q;
        logic               hit_sink;

        assign hit_sink = (reg_sink == SINK_W'(s));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q <= '0;
            end else begin
                case (reg_op)
                    OP_WRITE: begin
                        for (int w = 0; w < WORDS; w++) begin
                            if (reg_addr == ADDR_W'(s * WORDS + w))
                                mask_q[w*REG_W +: REG_W] <= reg_wdata;
                        end
                    end
                    OP_SET:  if (hit_sink) mask_q[reg_id] <= 1'b1;
                    OP_CLR:  if (hit_sink) mask_q[reg_id] <= 1'b0;
                    default: ;
                endcase
            end
        end

        assign look_sel[s]                         = mask_q[look_id];
        assign mask_flat[s*NUM_IDS +: NUM_IDS]     = mask_q;
    end

    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) < NUM_REGS)
            reg_rdata = mask_flat[int'(reg_addr)*REG_W +: REG_W];
    end
endmodule

// File: rtl/trf_deliver.sv
module trf_deliver #(
    parameter int NUM_SINKS = 2,
    parameter int ID_W      = 7,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [ID_W-1:0]      in_id,
    input  logic [DATA_W-1:0]    in_data,
    input  logic [NUM_SINKS-1:0] sel,
    output logic [NUM_SINKS-1:0] out_valid,
    input  logic [NUM_SINKS-1:0] out_ready,
    output logic [ID_W-1:0]      out_id,
    output logic [DATA_W-1:0]    out_data
);
    import trf_pkg::*;

    dlv_state_e           state_q, state_d;
    logic [NUM_SINKS-1:0] pend_q, pend_d;
    logic [ID_W-1:0]      id_q;
    logic [DATA_W-1:0]    data_q;
    logic                 load;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        pend_d    = pend_q;
        load      = 1'b0;
        in_ready  = 1'b0;
        out_valid = '0;
        unique case (state_q)
            ST_EMPTY: begin
                in_ready = 1'b1;
                if (in_valid && (|sel)) begin
                    load    = 1'b1;
                    pend_d  = sel;
                    state_d = ST_DELIVER;
                end
            end
            ST_DELIVER: begin
                out_valid = pend_q;
                pend_d    = pend_q & ~out_ready;
                if (pend_d == '0) state_d = ST_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            id_q   <= '0;
            data_q <= '0;
        end else begin
            pend_q <= pend_d;
            if (load) begin
                id_q   <= in_id;
                data_q <= in_data;
            end
        end
    end

    assign out_id   = id_q;
    assign out_data = data_q;
endmodule

// File: rtl/trace_id_filter.sv
module trace_id_filter #(
    parameter int NUM_SINKS = 2,
    parameter int ID_W      = 7,
    parameter int DATA_W    = 32,
    parameter int REG_W     = 32,
    localparam int NUM_IDS  = 1 << ID_W,
    localparam int NUM_REGS = NUM_SINKS * (NUM_IDS / REG_W),
    localparam int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int SINK_W   = (NUM_SINKS > 1) ? $clog2(NUM_SINKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [ID_W-1:0]      in_id,
    input  logic [DATA_W-1:0]    in_data,
    output logic [NUM_SINKS-1:0] out_valid,
    input  logic [NUM_SINKS-1:0] out_ready,
    output logic [ID_W-1:0]      out_id,
    output logic [DATA_W-1:0]    out_data,
    input  logic [1:0]           reg_op,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [SINK_W-1:0]    reg_sink,
    input  logic [ID_W-1:0]      reg_id,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata
);
    import trf_pkg::*;

    logic [NUM_SINKS-1:0]         sel_w;
    logic [NUM_SINKS*NUM_IDS-1:0] mask_w;
    reg_op_e                      op_w;

    assign op_w = reg_op_e'(reg_op);

    trf_mask_bank #(
        .NUM_SINKS(NUM_SINKS), .ID_W(ID_W), .REG_W(REG_W)
    ) i_bank (
        .clk(clk), .rst_n(rst_n),
        .reg_op(op_w), .reg_addr(reg_addr), .reg_sink(reg_sink),
        .reg_id(reg_id), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .look_id(in_id), .look_sel(sel_w), .mask_flat(mask_w)
    );

    trf_deliver #(
        .NUM_SINKS(NUM_SINKS), .ID_W(ID_W), .DATA_W(DATA_W)
    ) i_dlv (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_id(in_id), .in_data(in_data), .sel(sel_w),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_id(out_id), .out_data(out_data)
    );
endmodule

// File: rtl/trace_id_filter_chk.sv
module trace_id_filter_chk #(
    parameter int NUM_SINKS = 2,
    parameter int ID_W      = 7,
    parameter int DATA_W    = 32,
    parameter int MASK_W    = 256
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic [ID_W-1:0]      in_id,
    input logic [NUM_SINKS-1:0] sel,
    input logic [NUM_SINKS-1:0] out_valid,
    input logic [NUM_SINKS-1:0] out_ready,
    input logic [ID_W-1:0]      out_id,
    input logic [DATA_W-1:0]    out_data,
    input logic [1:0]           reg_op,
    input logic [MASK_W-1:0]    mask_flat
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (out_valid == '0)); // R7

    AST_BLOCKED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid != '0)); // R7

    AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (|(out_valid & ~out_ready)) |=> ($stable(out_data) && $stable(out_id))); // R6

    AST_ROUTE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (|sel)) |=> (out_valid == $past(sel) && out_id == $past(in_id))); // R5

    AST_DROP_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && sel == '0) |=> in_ready); // R8

    AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_op == 2'd2) |=> (($past(mask_flat) & ~mask_flat) == '0)); // R3

    AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_op == 2'd3) |=> ((mask_flat & ~$past(mask_flat)) == '0)); // R4

    for (genvar s = 0; s < NUM_SINKS; s++) begin : g_take
        AST_TAKE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[s] && out_ready[s]) |=> !out_valid[s]); // R6
    end
endmodule

bind trace_id_filter trace_id_filter_chk #(
    .NUM_SINKS(NUM_SINKS), .ID_W(ID_W), .DATA_W(DATA_W), .MASK_W(NUM_SINKS*NUM_IDS)
) i_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_id(in_id), .sel(sel_w), .out_valid(out_valid), .out_ready(out_ready),
    .out_id(out_id), .out_data(out_data), .reg_op(reg_op), .mask_flat(mask_w)
);

// File: tb/test_trace_id_filter.sv
module test_trace_id_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [6:0]  in_id = '0;
    logic [31:0] in_data = '0;
    logic [1:0]  out_valid;
    logic [1:0]  out_ready = '0;
    logic [6:0]  out_id;
    logic [31:0] out_data;
    logic [1:0]  reg_op = '0;
    logic [2:0]  reg_addr = '0;
    logic [0:0]  reg_sink = '0;
    logic [6:0]  reg_id = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #10 clk = ~clk; // 50 MHz

    trace_id_filter i_trace_id_filter (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 50000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_cmd(input logic [1:0] op, input logic [2:0] a, input logic s,
                           input logic [6:0] id, input logic [31:0] d);
        @(negedge clk);
        reg_op = op; reg_addr = a; reg_sink = s; reg_id = id; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_op = 2'd0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic clear_all();
        for (int a = 0; a < 8; a++) reg_cmd(2'd1, 3'(a), 1'b0, 7'd0, 32'd0);
    endtask

    task automatic send(input logic [6:0] id, input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_id = id; in_data = d;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk(v == 0, "R1 reset word", v, 0);
        end
        chk(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
        chk(out_valid == 2'b00, "R1 reset out_valid", out_valid, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        reg_cmd(2'd1, 3'd5, 1'b0, 7'd0, 32'hA5A5_0F0F);
        rd(3'd5, v); chk(v == 32'hA5A5_0F0F, "R2 write/read word5", v, 32'hA5A5_0F0F);
        rd(3'd4, v); chk(v == 0, "R2 neighbour word4 untouched", v, 0);
        clear_all();
        reg_cmd(2'd2, 3'd0, 1'b0, 7'd5, 32'd0);
        rd(3'd0, v); chk(v == 32'h20, "R2 sink0 id5 -> word0 bit5", v, 32'h20);
        reg_cmd(2'd2, 3'd0, 1'b1, 7'd70, 32'd0);
        rd(3'd6, v); chk(v == 32'h40, "R2 sink1 id70 -> word6 bit6", v, 32'h40);
        reg_cmd(2'd2, 3'd0, 1'b1, 7'd127, 32'd0);
        rd(3'd7, v); chk(v == 32'h8000_0000, "R2 sink1 id127 -> word7 bit31", v, 32'h8000_0000);
        clear_all();
    endtask

    task automatic t_set_clear();
        logic [31:0] v;
        reg_cmd(2'd1, 3'd0, 1'b0, 7'd0, 32'h00F0_0001);
        reg_cmd(2'd2, 3'd0, 1'b0, 7'd5, 32'd0);
        rd(3'd0, v); chk(v == 32'h00F0_0021, "R3 set id5 keeps others", v, 32'h00F0_0021);
        reg_cmd(2'd3, 3'd0, 1'b0, 7'd20, 32'd0);
        rd(3'd0, v); chk(v == 32'h00E0_0021, "R4 clear id20 keeps others", v, 32'h00E0_0021);
        reg_cmd(2'd3, 3'd0, 1'b0, 7'd5, 32'd0);
        rd(3'd0, v); chk(v == 32'h00E0_0001, "R4 clear id5", v, 32'h00E0_0001);
        reg_cmd(2'd0, 3'd0, 1'b0, 7'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); chk(v == 32'h00E0_0001, "R4 no-op leaves word", v, 32'h00E0_0001);
        rd(3'd4, v); chk(v == 0, "R3 other sink untouched", v, 0);
        clear_all();
    endtask

    task automatic t_single_sink();
        reg_cmd(2'd2, 3'd0, 1'b0, 7'd9, 32'd0);
        out_ready = 2'b00;
        send(7'd9, 32'hDEAD_0001);
        chk(out_valid == 2'b01, "R5 sink0 only", out_valid, 2'b01);
        chk(out_id == 7'd9, "R5 out_id", out_id, 9);
        chk(out_data == 32'hDEAD_0001, "R5 out_data", out_data, 32'hDEAD_0001);
        chk(in_ready == 1'b0, "R7 blocked while pending", in_ready, 0);
        @(negedge clk);
        chk(out_valid == 2'b01 && out_data == 32'hDEAD_0001, "R6 held while stalled", out_data, 32'hDEAD_0001);
        out_ready = 2'b01;
        @(negedge clk);
        out_ready = 2'b00;
        chk(out_valid == 2'b00, "R6 dropped after take", out_valid, 0);
        chk(in_ready == 1'b1, "R7 ready after all taken", in_ready, 1);
        reg_cmd(2'd2, 3'd0, 1'b1, 7'd100, 32'd0);
        send(7'd100, 32'hBEEF_0002);
        chk(out_valid == 2'b10, "R5 sink1 only id100", out_valid, 2'b10);
        out_ready = 2'b10;
        @(negedge clk);
        out_ready = 2'b00;
        chk(out_valid == 2'b00, "R6 sink1 took beat", out_valid, 0);
    endtask

    task automatic t_multicast();
        reg_cmd(2'd2, 3'd0, 1'b1, 7'd9, 32'd0);
        send(7'd9, 32'h1234_5678);
        chk(out_valid == 2'b11, "R6 both sinks offered", out_valid, 2'b11);
        out_ready = 2'b10;
        @(negedge clk);
        out_ready = 2'b00;
        chk(out_valid == 2'b01, "R6 sink1 took, sink0 pending", out_valid, 2'b01);
        chk(in_ready == 1'b0, "R7 still blocked", in_ready, 0);
        chk(out_data == 32'h1234_5678, "R6 data stable", out_data, 32'h1234_5678);
        out_ready = 2'b01;
        @(negedge clk);
        out_ready = 2'b00;
        chk(out_valid == 2'b00 && in_ready == 1'b1, "R7 released", {in_ready, out_valid}, 3'b100);
    endtask

    task automatic t_drop();
        send(7'd50, 32'hCAFE_0003);
        chk(out_valid == 2'b00, "R8 unselected no valid", out_valid, 0);
        chk(in_ready == 1'b1, "R8 unselected still ready", in_ready, 1);
        send(7'd5, 32'hCAFE_0004);
        chk(out_valid == 2'b00, "R5 cleared bit never valid", out_valid, 0);
    endtask

    task automatic t_snapshot();
        send(7'd9, 32'h5555_AAAA);
        chk(out_valid == 2'b11, "R9 pending on both", out_valid, 2'b11);
        reg_cmd(2'd3, 3'd0, 1'b0, 7'd9, 32'd0);
        chk(out_valid == 2'b11, "R9 mask edit not applied to pending beat", out_valid, 2'b11);
        out_ready = 2'b11;
        @(negedge clk);
        out_ready = 2'b00;
        chk(out_valid == 2'b00, "R9 both took", out_valid, 0);
        send(7'd9, 32'h5555_BBBB);
        chk(out_valid == 2'b10, "R9 edit applies to next beat", out_valid, 2'b10);
        out_ready = 2'b10;
        @(negedge clk);
        out_ready = 2'b00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_set_clear();
        t_single_sink();
        t_multicast();
        t_drop();
        t_snapshot();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule